// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block generates the per-cycle control lines of a multicycle processor datapath. The control lines come from a microcode ROM rather than from a hardwired state machine. A 4-bit micro-program counter addresses a ROM of 18-bit microinstructions. Each word carries the datapath control fields and a 2-bit sequencing code. The sequencing code decides where the counter goes on the next rising clock edge: back to the fetch word, to the entry of one of two 64-entry lookup tables indexed by the current 6-bit opcode, or to the next address.

The microcode implements a ten-word program. It covers fetch, decode, effective-address calculation, load read and write-back, store, R-type execute and write-back, conditional branch, and jump. The control outputs depend only on the micro-PC, so they are valid for the whole cycle that follows each clock edge. The opcode is only looked at on the edges that leave the decode word and the address-calculation word.

Top module: `mseq_ctrl`

## Requirements
- R1: While rst_ni is low, the micro-PC is held at 0, and this takes effect without a clock edge. The outputs then show the fetch word. After reset is released, the first rising edge moves the sequencer to the decode word.
- R2: The microinstruction is laid out MSB first as follows. Bits 17:16 are the ALU op and bit 15 is the ALU A source. Bits 14:13 are the ALU B source. Bits 12, 11 and 10 are reg write, mem-to-reg and reg dest. Bits 9, 8, 7 and 6 are mem read, mem write, address-from-ALU-result and IR write. Bit 5 is PC write, bit 4 is conditional PC write, bits 3:2 are the PC source and bits 1:0 are the sequencing code. Each field drives the output of the same name.
- R3: On each rising edge the next micro-address depends on the sequencing code. Code 00 gives 0. Code 01 gives the entry of table 1 for the opcode and code 10 gives the entry of table 2. Code 11 gives the current address plus 1.
- R4: Table 1 maps opcode 6'h23 (load) and 6'h2B (store) to 2, 6'h00 (R-type) to 6, 6'h04 (branch) to 8 and 6'h02 (jump) to 9.
- R5: Table 2 maps 6'h23 to 3 and 6'h2B to 5. It is indexed by the opcode present at the edge that leaves word 2, not by the opcode present at decode.
- R6: Every table entry not listed in R4 or R5 holds 0, so an unknown opcode returns the sequencer to fetch.
- R7: The word orders are as follows. Load runs 0,1,2,3,4. Store runs 0,1,2,5. R-type runs 0,1,6,7. Branch runs 0,1,8 and jump runs 0,1,9. After the last word of each order, the next word is 0.
- R8: Each word asserts only the lines listed here, and all others are 0.
  - Word 0: mem read, IR write, PC write, B source 01.
  - Word 1: B source 11.
  - Word 2: A source, B source 10.
  - Word 3: mem read, address-from-ALU-result.
  - Word 4: reg write, mem-to-reg.
  - Word 5: mem write, address-from-ALU-result.
  - Word 6: A source, ALU op 10.
  - Word 7: reg write, reg dest.
  - Word 8: A source, ALU op 01, conditional PC write, PC source 01.
  - Word 9: PC write, PC source 10.
- R9: A change of opcode has no effect outside the two dispatch edges. Mem read and mem write are never high together, and IR write is only high together with mem read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Current instruction opcode |
| alu_op_o | output | 2 | ALU operation select |
| alu_src_a_o | output | 1 | ALU A operand source |
| alu_src_b_o | output | 2 | ALU B operand source |
| reg_write_o | output | 1 | Register file write enable |
| mem_to_reg_o | output | 1 | Write-back data from memory data register |
| reg_dst_o | output | 1 | Destination register from rd field |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| i_or_d_o | output | 1 | Memory address from ALU result register |
| ir_write_o | output | 1 | Instruction register write |
| pc_write_o | output | 1 | Unconditional PC write |
| pc_write_cond_o | output | 1 | PC write when ALU zero |
| pc_src_o | output | 2 | PC source select |

## Verification
Each of the five legal opcodes is walked through its full word order. These walks tell apart the four table 1 targets, the two table 2 targets, and the two return-to-fetch points. An unknown opcode at decode shows the empty table entries, and an R-type opcode held at word 2 shows the empty table 2 entries. A store opcode that changes to load between the two dispatch edges shows that table 2 reads the live opcode. A branch opcode applied in the middle of a load, and a reset asserted in the middle of a sequence, show that the opcode is ignored outside dispatch and that reset takes effect without a clock edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int OP_W  = 6;
  localparam int UPC_W = 4;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_NEXT  = 2'b11
  } seq_e;

  typedef struct packed {
    logic [1:0] alu_op;
    logic       src_a;
    logic [1:0] src_b;
    logic       reg_write;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       mem_read;
    logic       mem_write;
    logic       i_or_d;
    logic       ir_write;
    logic       pc_write;
    logic       pc_write_cond;
    logic [1:0] pc_src;
    seq_e       seq;
  } uinstr_t;

  localparam int UWORD_W = $bits(uinstr_t);

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
endpackage

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
  import mseq_pkg::*;
#(
  parameter int OPW   = OP_W,
  parameter int UPCW  = UPC_W,
  parameter int TABLE = 1
) (
  input  logic [OPW-1:0]  opcode_i,
  output logic [UPCW-1:0] target_o
);
  localparam int DEPTH = 2 ** OPW;

  function automatic logic [UPCW-1:0] entry_f(input logic [OPW-1:0] op);
    logic [UPCW-1:0] t;
    t = '0;
    if (TABLE == 1) begin
      case (op)
        OPC_LOAD, OPC_STORE: t = UPCW'(2);
        OPC_RTYPE:           t = UPCW'(6);
        OPC_BEQ:             t = UPCW'(8);
        OPC_JUMP:            t = UPCW'(9);
        default:             t = '0;
      endcase
    end else begin
      case (op)
        OPC_LOAD:  t = UPCW'(3);
        OPC_STORE: t = UPCW'(5);
        default:   t = '0;
      endcase
    end
    return t;
  endfunction

  logic [UPCW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign tbl[i] = entry_f(OPW'(i));
  end

  assign target_o = tbl[opcode_i];
endmodule

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
#(
  parameter int UPCW = UPC_W
) (
  input  logic [UPCW-1:0] addr_i,
  output uinstr_t         word_o
);
  always_comb begin
    word_o     = '0;
    word_o.seq = SEQ_FETCH;
    case (addr_i)
      UPCW'(0): begin  // fetch
        word_o.mem_read = 1'b1;
        word_o.ir_write = 1'b1;
        word_o.src_b    = 2'b01;
        word_o.pc_write = 1'b1;
        word_o.seq      = SEQ_NEXT;
      end
      UPCW'(1): begin  // decode, branch target
        word_o.src_b = 2'b11;
        word_o.seq   = SEQ_DISP1;
      end
      UPCW'(2): begin  // effective address
        word_o.src_a = 1'b1;
        word_o.src_b = 2'b10;
        word_o.seq   = SEQ_DISP2;
      end
      UPCW'(3): begin  // load read
        word_o.mem_read = 1'b1;
        word_o.i_or_d   = 1'b1;
        word_o.seq      = SEQ_NEXT;
      end
      UPCW'(4): begin  // load write-back
        word_o.reg_write  = 1'b1;
        word_o.mem_to_reg = 1'b1;
      end
      UPCW'(5): begin  // store
        word_o.mem_write = 1'b1;
        word_o.i_or_d    = 1'b1;
      end
      UPCW'(6): begin  // R-type execute
        word_o.src_a  = 1'b1;
        word_o.alu_op = 2'b10;
        word_o.seq    = SEQ_NEXT;
      end
      UPCW'(7): begin  // R-type write-back
        word_o.reg_write = 1'b1;
        word_o.reg_dst   = 1'b1;
      end
      UPCW'(8): begin  // branch
        word_o.src_a         = 1'b1;
        word_o.alu_op        = 2'b01;
        word_o.pc_write_cond = 1'b1;
        word_o.pc_src        = 2'b01;
      end
      UPCW'(9): begin  // jump
        word_o.pc_write = 1'b1;
        word_o.pc_src   = 2'b10;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mseq_upc.sv
module mseq_upc
  import mseq_pkg::*;
#(
  parameter int UPCW = UPC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_e            seq_i,
  input  logic [UPCW-1:0] disp1_i,
  input  logic [UPCW-1:0] disp2_i,
  output logic [UPCW-1:0] upc_o
);
  logic [UPCW-1:0] upc_q, upc_d;

  always_comb begin
    unique case (seq_i)
      SEQ_FETCH: upc_d = '0;
      SEQ_DISP1: upc_d = disp1_i;
      SEQ_DISP2: upc_d = disp2_i;
      SEQ_NEXT:  upc_d = upc_q + UPCW'(1);
      default:   upc_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int UPCW = UPC_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] opcode_i,
  output logic [1:0]     alu_op_o,
  output logic           alu_src_a_o,
  output logic [1:0]     alu_src_b_o,
  output logic           reg_write_o,
  output logic           mem_to_reg_o,
  output logic           reg_dst_o,
  output logic           mem_read_o,
  output logic           mem_write_o,
  output logic           i_or_d_o,
  output logic           ir_write_o,
  output logic           pc_write_o,
  output logic           pc_write_cond_o,
  output logic [1:0]     pc_src_o
);
  logic [UPCW-1:0] upc, disp1, disp2;
  uinstr_t         uword;

  mseq_dispatch #(.OPW(OPW), .UPCW(UPCW), .TABLE(1)) i_disp1 (
    .opcode_i(opcode_i), .target_o(disp1)
  );

  mseq_dispatch #(.OPW(OPW), .UPCW(UPCW), .TABLE(2)) i_disp2 (
    .opcode_i(opcode_i), .target_o(disp2)
  );

  mseq_upc #(.UPCW(UPCW)) i_upc (
    .clk_i(clk_i), .rst_ni(rst_ni), .seq_i(uword.seq),
    .disp1_i(disp1), .disp2_i(disp2), .upc_o(upc)
  );

  mseq_rom #(.UPCW(UPCW)) i_rom (
    .addr_i(upc), .word_o(uword)
  );

  assign alu_op_o        = uword.alu_op;
  assign alu_src_a_o     = uword.src_a;
  assign alu_src_b_o     = uword.src_b;
  assign reg_write_o     = uword.reg_write;
  assign mem_to_reg_o    = uword.mem_to_reg;
  assign reg_dst_o       = uword.reg_dst;
  assign mem_read_o      = uword.mem_read;
  assign mem_write_o     = uword.mem_write;
  assign i_or_d_o        = uword.i_or_d;
  assign ir_write_o      = uword.ir_write;
  assign pc_write_o      = uword.pc_write;
  assign pc_write_cond_o = uword.pc_write_cond;
  assign pc_src_o        = uword.pc_src;
endmodule

// File: rtl/mseq_ctrl_chk.sv
module mseq_ctrl_chk
  import mseq_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int UPCW = UPC_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OPW-1:0]  opcode_i,
  input logic [UPCW-1:0] upc,
  input seq_e            seq,
  input logic            mem_read_o,
  input logic            mem_write_o,
  input logic            ir_write_o
);
  p_fetch_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq == SEQ_FETCH |=> upc == '0);

  p_next_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq == SEQ_NEXT |=> upc == UPCW'($past(upc) + UPCW'(1)));

  p_load_decode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SEQ_DISP1 && opcode_i == OPC_LOAD) |=> upc == UPCW'(2));

  p_branch_decode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SEQ_DISP1 && opcode_i == OPC_BEQ) |=> upc == UPCW'(8));

  p_store_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SEQ_DISP2 && opcode_i == OPC_STORE) |=> upc == UPCW'(5));

  p_unknown_op_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SEQ_DISP1 && opcode_i == 6'h3F) |=> upc == '0);

  p_mem_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_read_o, mem_write_o}));

  p_ir_needs_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_write_o |-> mem_read_o);
endmodule

bind mseq_ctrl mseq_ctrl_chk #(.OPW(OPW), .UPCW(UPCW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .upc(upc),
  .seq(uword.seq), .mem_read_o(mem_read_o), .mem_write_o(mem_write_o),
  .ir_write_o(ir_write_o)
);

// File: tb/test_mseq_ctrl.sv
module test_mseq_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode = 6'h00;

  logic [1:0] alu_op, src_b, pc_src;
  logic src_a, rw, mtr, rd, mr, mw, iod, irw, pcw, pcwc;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mseq_ctrl i_mseq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode),
    .alu_op_o(alu_op), .alu_src_a_o(src_a), .alu_src_b_o(src_b),
    .reg_write_o(rw), .mem_to_reg_o(mtr), .reg_dst_o(rd),
    .mem_read_o(mr), .mem_write_o(mw), .i_or_d_o(iod), .ir_write_o(irw),
    .pc_write_o(pcw), .pc_write_cond_o(pcwc), .pc_src_o(pc_src)
  );

  wire [15:0] ctl = {alu_op, src_a, src_b, rw, mtr, rd, mr, mw, iod, irw,
                     pcw, pcwc, pc_src};

  // Expected lines per word, from R8
  function automatic logic [15:0] exp_ctl(input int s);
    case (s)
      0: return {2'b00, 1'b0, 2'b01, 3'b000, 4'b1001, 4'b1000};
      1: return {2'b00, 1'b0, 2'b11, 3'b000, 4'b0000, 4'b0000};
      2: return {2'b00, 1'b1, 2'b10, 3'b000, 4'b0000, 4'b0000};
      3: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b1010, 4'b0000};
      4: return {2'b00, 1'b0, 2'b00, 3'b110, 4'b0000, 4'b0000};
      5: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b0110, 4'b0000};
      6: return {2'b10, 1'b1, 2'b00, 3'b000, 4'b0000, 4'b0000};
      7: return {2'b00, 1'b0, 2'b00, 3'b101, 4'b0000, 4'b0000};
      8: return {2'b01, 1'b1, 2'b00, 3'b000, 4'b0000, 4'b0101};
      9: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b0000, 4'b1010};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input int s, input string req);
    tests++;
    if (ctl !== exp_ctl(s)) begin
      fails++;
      $display("FAIL %s: word %0d actual %h expected %h", req, s, ctl, exp_ctl(s));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // opcode, length, word order packed with first word in [3:0]
  localparam int NV = 7;
  localparam logic [5:0]  V_OP  [NV] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02, 6'h3F, 6'h23};
  localparam int          V_LEN [NV] = '{5, 4, 4, 3, 3, 2, 5};
  localparam logic [19:0] V_SEQ [NV] = '{20'h43210, 20'h05210, 20'h07610,
                                         20'h00810, 20'h00910, 20'h00010, 20'h43210};
  localparam string       V_REQ [NV] = '{"R4 R5 R7 load", "R4 R5 R7 store", "R4 R7 rtype",
                                         "R4 R7 branch", "R4 R7 jump", "R6 unknown",
                                         "R2 R3 R8 load after unknown"};

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(0, "R1 in reset");
    step();
    check(0, "R1 held in reset across edge");
    rst_ni = 1'b1;

    // vector walk; every order ends back at word 0, checked by next vector
    for (int v = 0; v < NV; v++) begin
      opcode = V_OP[v];
      for (int k = 0; k < V_LEN[v]; k++) begin
        check(int'(V_SEQ[v][k*4 +: 4]), V_REQ[v]);
        step();
      end
    end
    check(0, "R7 return to fetch");

    // R9: opcode change mid-sequence ignored
    opcode = 6'h23;
    step(); step(); step();
    opcode = 6'h04;
    check(3, "R9 load word 3 with branch opcode");
    step();
    check(4, "R9 load word 4 with branch opcode");
    step();
    check(0, "R9 back to fetch");

    // R5: table 2 uses live opcode
    opcode = 6'h2B;
    step(); step();
    check(2, "R5 address word");
    opcode = 6'h23;
    step();
    check(3, "R5 live opcode load at word 2");
    step(); step();
    check(0, "R5 back to fetch");

    // R6: empty table 2 entry
    opcode = 6'h23;
    step(); step();
    opcode = 6'h00;
    check(2, "R6 address word");
    step();
    check(0, "R6 table 2 empty entry to fetch");

    // R1: async reset mid-sequence
    opcode = 6'h23;
    step(); step(); step();
    check(3, "R1 before reset");
    #1 rst_ni = 1'b0;
    #0.5;
    check(0, "R1 async reset without edge");
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    check(1, "R1 decode after release");
    step();
    check(2, "R1 load continues");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule